// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port static RAM. Two identical ports, left and right, each run on their own clock. Either port can read or write any word at any time, and both ports may reach the same word in the same cycle. Each port registers its address, its controls and its write data on the rising edge of its clock. Two select inputs gate each port, and the port performs an access only when both are in their active state. Writes are byte-granular: an upper lane covers bits 15:8 and a lower lane covers bits 7:0.

Each port has a burst address counter. The counter can be cleared to zero, loaded from the external address, stepped by one or held. Every access uses the value the counter takes in that cycle. A burst of reads or writes therefore needs an address only on its first cycle.

Each port picks its own read timing:
- In flow-through mode, data appears in the cycle after the capturing edge.
- In pipelined mode, data passes through one more register and appears one clock later.

The output is a data word plus a valid flag. The output-enable input blanks both at once, with no clock involved.

`ADDR_W` sets the depth. The full-size configuration uses `ADDR_W = 14` for 16K words. The default is smaller so that a quick elaboration stays light.

Top module: `dual_port_burst_ram`

## Requirements
- R1: While `rst_n` is low and after it is released, both `rvalid_*` outputs are 0, both `rdata_*` outputs are 0, and both address counters are 0.
- R2: A port is selected only when `sel0_n_*` is 0 and `sel1_*` is 1. In any other combination that port writes nothing and returns no read, so `rvalid_*` stays 0.
- R3: When a port is selected and `wr_n_*` is 0, the port writes `wdata_*`. `upper_n_*` = 0 enables bits 15:8 and `lower_n_*` = 0 enables bits 7:0. A lane whose enable is 1 keeps its stored contents.
- R4: With `pipe_*` = 0, a read captured at edge k drives `rvalid_*` = 1 and the word onto `rdata_*` after edge k. Both hold until edge k+1.
- R5: With `pipe_*` = 1, a read captured at edge k reaches `rdata_*`/`rvalid_*` only after edge k+1.
- R6: The counter's next value follows this priority:
  - `clr_n_*` = 0 gives 0.
  - Otherwise `load_n_*` = 0 gives `addr_*`.
  - Otherwise `step_n_*` = 0 gives the current value plus 1.
  - Otherwise the value holds.
  The access in that cycle uses this next value.
- R7: A counter clear costs no cycle. A read or write issued in the clear cycle is performed at address 0.
- R8: Stepping from the top address (2^ADDR_W − 1) wraps the counter to 0.
- R9: `oe_n_*` = 1 forces that port's `rvalid_*` and `rdata_*` to 0 at once, with no clock edge. Releasing it restores the held read.
- R10: Both ports can access the same word on the same edge. A read of a word that the other port writes on that same edge returns the old contents. The new contents are visible from the next cycle.
- R11: If both ports write the same word on the same edge, every lane the left port writes takes the left data. Lanes written only by the right port take the right data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of port registers and counters |
| clk_l | input | 1 | Left port clock |
| addr_l | input | ADDR_W | Left external address |
| load_n_l | input | 1 | Left counter load from `addr_l`, active low |
| step_n_l | input | 1 | Left counter increment, active low |
| clr_n_l | input | 1 | Left counter clear, active low |
| sel0_n_l | input | 1 | Left select, active low |
| sel1_l | input | 1 | Left select, active high |
| wr_n_l | input | 1 | Left write (0) or read (1) |
| upper_n_l | input | 1 | Left upper lane enable, active low |
| lower_n_l | input | 1 | Left lower lane enable, active low |
| oe_n_l | input | 1 | Left output enable, active low |
| pipe_l | input | 1 | Left read timing: 1 pipelined, 0 flow-through |
| wdata_l | input | DATA_W | Left write data |
| rdata_l | output | DATA_W | Left read data, 0 when not valid |
| rvalid_l | output | 1 | Left read data is being driven |
| clk_r | input | 1 | Right port clock |
| addr_r | input | ADDR_W | Right external address |
| load_n_r | input | 1 | Right counter load, active low |
| step_n_r | input | 1 | Right counter increment, active low |
| clr_n_r | input | 1 | Right counter clear, active low |
| sel0_n_r | input | 1 | Right select, active low |
| sel1_r | input | 1 | Right select, active high |
| wr_n_r | input | 1 | Right write (0) or read (1) |
| upper_n_r | input | 1 | Right upper lane enable, active low |
| lower_n_r | input | 1 | Right lower lane enable, active low |
| oe_n_r | input | 1 | Right output enable, active low |
| pipe_r | input | 1 | Right read timing select |
| wdata_r | input | DATA_W | Right write data |
| rdata_r | output | DATA_W | Right read data, 0 when not valid |
| rvalid_r | output | 1 | Right read data is being driven |

## Verification
The bench drives inputs on the falling edge and samples outputs at the next falling edge.
- A write is visible to any read captured on a later edge.
- A flow-through read is checked half a cycle after its capturing edge.
- A pipelined read is first checked at that point to confirm it is still absent, then checked again one full cycle later.
- The output-enable response is checked one time unit after the input changes, in the middle of a cycle, to show it needs no edge.
- The same-edge cases for R10 and R11 drive both ports in one cycle and then read the result on a following cycle.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;

  typedef enum logic [1:0] {
    CNT_CLEAR,
    CNT_LOAD,
    CNT_STEP,
    CNT_KEEP
  } cnt_op_e;

  // priority: clear, then load, then step, else keep
  function automatic cnt_op_e cnt_decode(input logic clr_n, input logic load_n,
                                         input logic step_n);
    if (!clr_n) return CNT_CLEAR;
    if (!load_n) return CNT_LOAD;
    if (!step_n) return CNT_STEP;
    return CNT_KEEP;
  endfunction

  function automatic logic port_selected(input logic sel0_n, input logic sel1);
    return !sel0_n && sel1;
  endfunction

endpackage

// File: rtl/dpbr_bank.sv
// One write-owner storage bank. The stored value is XOR-coded against the
// other bank, so each bank has exactly one writing clock domain.
module dpbr_bank #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [1:0]        wr_lane,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (wr_lane[k]) mem[wr_addr][k*LANE_W +: LANE_W] <= wr_data[k*LANE_W +: LANE_W];
    end
  end

  assign rd_a = mem[rd_addr_a];
  assign rd_b = mem[rd_addr_b];
endmodule

// File: rtl/dpbr_port.sv
module dpbr_port
  import dpbr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              step_n,
  input  logic              clr_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              wr_n,
  input  logic              upper_n,
  input  logic              lower_n,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        wr_lane,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  function automatic logic [ADDR_W-1:0] burst_addr(input cnt_op_e op,
                                                   input logic [ADDR_W-1:0] cur,
                                                   input logic [ADDR_W-1:0] ext);
    case (op)
      CNT_CLEAR: return '0;
      CNT_LOAD:  return ext;
      CNT_STEP:  return cur + ADDR_W'(1);
      default:   return cur;
    endcase
  endfunction

  logic [ADDR_W-1:0] ptr_q;
  cnt_op_e           cnt_op;
  logic              sel_now, wr_fire, rd_fire;
  logic              s1_v, s2_v;
  logic [DATA_W-1:0] s1_d, s2_d;
  logic              out_v;
  logic [DATA_W-1:0] out_d;

  assign cnt_op   = cnt_decode(clr_n, load_n, step_n);
  assign acc_addr = burst_addr(cnt_op, ptr_q, ext_addr);
  assign sel_now  = port_selected(sel0_n, sel1);
  assign wr_fire  = sel_now && !wr_n;
  assign rd_fire  = sel_now && wr_n;
  assign wr_lane  = {2{wr_fire}} & ~{upper_n, lower_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      s1_d  <= '0;
      s2_d  <= '0;
    end else begin
      ptr_q <= acc_addr;
      s1_v  <= rd_fire;
      s1_d  <= rd_word;
      s2_v  <= s1_v;
      s2_d  <= s1_d;
    end
  end

  assign out_v  = pipe ? s2_v : s1_v;
  assign out_d  = pipe ? s2_d : s1_d;
  assign rvalid = out_v && !oe_n;
  assign rdata  = rvalid ? out_d : '0;

  // counter priority and access address (R6, R7, R8)
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> ptr_q == '0)
    else $error("counter clear did not reach 0");

  p_cnt_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && !load_n |=> ptr_q == $past(ext_addr))
    else $error("counter load mismatch");

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && load_n && !step_n |=> ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1)))
    else $error("counter step mismatch");

  p_cnt_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n && load_n && step_n |=> $stable(ptr_q))
    else $error("counter did not hold");

  p_oe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rvalid && rdata == '0)
    else $error("output driven while disabled");

  p_desel_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_now && !pipe && $stable(pipe) |=> !rvalid)
    else $error("deselected port produced a read");
endmodule

// File: rtl/dual_port_burst_ram.sv
module dual_port_burst_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              rst_n,
  input  logic              clk_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              load_n_l,
  input  logic              step_n_l,
  input  logic              clr_n_l,
  input  logic              sel0_n_l,
  input  logic              sel1_l,
  input  logic              wr_n_l,
  input  logic              upper_n_l,
  input  logic              lower_n_l,
  input  logic              oe_n_l,
  input  logic              pipe_l,
  input  logic [DATA_W-1:0] wdata_l,
  output logic [DATA_W-1:0] rdata_l,
  output logic              rvalid_l,
  input  logic              clk_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              load_n_r,
  input  logic              step_n_r,
  input  logic              clr_n_r,
  input  logic              sel0_n_r,
  input  logic              sel1_r,
  input  logic              wr_n_r,
  input  logic              upper_n_r,
  input  logic              lower_n_r,
  input  logic              oe_n_r,
  input  logic              pipe_r,
  input  logic [DATA_W-1:0] wdata_r,
  output logic [DATA_W-1:0] rdata_r,
  output logic              rvalid_r
);
  localparam int NPORT = 2;

  logic              pclk     [NPORT];
  logic [ADDR_W-1:0] acc      [NPORT];
  logic [1:0]        lane_raw [NPORT];
  logic [1:0]        lane_eff [NPORT];
  logic [DATA_W-1:0] wdat     [NPORT];
  logic [DATA_W-1:0] store    [NPORT];
  logic [DATA_W-1:0] bank_a   [NPORT];  // bank contents at left address
  logic [DATA_W-1:0] bank_b   [NPORT];  // bank contents at right address
  logic [DATA_W-1:0] word     [NPORT];  // decoded word at each port's address
  logic              same_addr;
  logic [1:0]        collide_lane;

  assign pclk[0] = clk_l;
  assign pclk[1] = clk_r;
  assign wdat[0] = wdata_l;
  assign wdat[1] = wdata_r;

  dpbr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_l (
    .clk(clk_l), .rst_n(rst_n), .ext_addr(addr_l), .load_n(load_n_l),
    .step_n(step_n_l), .clr_n(clr_n_l), .sel0_n(sel0_n_l), .sel1(sel1_l),
    .wr_n(wr_n_l), .upper_n(upper_n_l), .lower_n(lower_n_l), .oe_n(oe_n_l),
    .pipe(pipe_l), .rd_word(word[0]), .acc_addr(acc[0]), .wr_lane(lane_raw[0]),
    .rdata(rdata_l), .rvalid(rvalid_l)
  );

  dpbr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_r (
    .clk(clk_r), .rst_n(rst_n), .ext_addr(addr_r), .load_n(load_n_r),
    .step_n(step_n_r), .clr_n(clr_n_r), .sel0_n(sel0_n_r), .sel1(sel1_r),
    .wr_n(wr_n_r), .upper_n(upper_n_r), .lower_n(lower_n_r), .oe_n(oe_n_r),
    .pipe(pipe_r), .rd_word(word[1]), .acc_addr(acc[1]), .wr_lane(lane_raw[1]),
    .rdata(rdata_r), .rvalid(rvalid_r)
  );

  // same-edge write collision: left lanes take precedence
  assign same_addr    = acc[0] == acc[1];
  assign collide_lane = lane_raw[0] & {2{same_addr}};
  assign lane_eff[0]  = lane_raw[0];
  assign lane_eff[1]  = lane_raw[1] & ~collide_lane;

  assign word[0]  = bank_a[0] ^ bank_a[1];
  assign word[1]  = bank_b[0] ^ bank_b[1];
  assign store[0] = wdat[0] ^ bank_a[1];
  assign store[1] = wdat[1] ^ bank_b[0];

  for (genvar g = 0; g < NPORT; g++) begin : g_bank
    dpbr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk(pclk[g]), .wr_lane(lane_eff[g]), .wr_addr(acc[g]), .wr_data(store[g]),
      .rd_addr_a(acc[0]), .rd_addr_b(acc[1]), .rd_a(bank_a[g]), .rd_b(bank_b[g])
    );
  end

  p_right_yields_r11: assert property (@(posedge clk_r) disable iff (!rst_n)
    (collide_lane != 2'b00) |-> (lane_eff[1] & lane_raw[0]) == 2'b00)
    else $error("right port wrote a lane the left port owns");
endmodule

// File: tb/dual_port_burst_ram_test.sv
module dual_port_burst_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr [2];
  logic load_n [2], step_n [2], clr_n [2], sel0_n [2], sel1 [2], wr_n [2];
  logic upper_n [2], lower_n [2], oe_n [2], pipe [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata_l, rdata_r;
  logic rvalid_l, rvalid_r;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_port_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .rst_n(rst_n),
    .clk_l(clk), .addr_l(addr[0]), .load_n_l(load_n[0]), .step_n_l(step_n[0]),
    .clr_n_l(clr_n[0]), .sel0_n_l(sel0_n[0]), .sel1_l(sel1[0]), .wr_n_l(wr_n[0]),
    .upper_n_l(upper_n[0]), .lower_n_l(lower_n[0]), .oe_n_l(oe_n[0]),
    .pipe_l(pipe[0]), .wdata_l(wdata[0]), .rdata_l(rdata_l), .rvalid_l(rvalid_l),
    .clk_r(clk), .addr_r(addr[1]), .load_n_r(load_n[1]), .step_n_r(step_n[1]),
    .clr_n_r(clr_n[1]), .sel0_n_r(sel0_n[1]), .sel1_r(sel1[1]), .wr_n_r(wr_n[1]),
    .upper_n_r(upper_n[1]), .lower_n_r(lower_n[1]), .oe_n_r(oe_n[1]),
    .pipe_r(pipe[1]), .wdata_r(wdata[1]), .rdata_r(rdata_r), .rvalid_r(rvalid_r)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic c_n, input logic l_n, input logic s_n,
                       input logic [AW-1:0] a, input logic s0_n, input logic s1,
                       input logic w_n, input logic u_n, input logic lo_n,
                       input logic [DW-1:0] d);
    clr_n[p] = c_n; load_n[p] = l_n; step_n[p] = s_n; addr[p] = a;
    sel0_n[p] = s0_n; sel1[p] = s1; wr_n[p] = w_n;
    upper_n[p] = u_n; lower_n[p] = lo_n; wdata[p] = d;
  endtask

  task automatic idle(input int p);
    drive(p, 1, 1, 1, '0, 1, 0, 1, 1, 1, '0);
  endtask
  task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive(p, 1, 0, 1, a, 0, 1, 0, 0, 0, d);
  endtask
  task automatic rd(input int p, input logic [AW-1:0] a);
    drive(p, 1, 0, 1, a, 0, 1, 1, 1, 1, '0);
  endtask
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // flow-through read on the left port, checked after the capturing edge
  task automatic read_left(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    rd(0, a); step();
    chk(req, DW'(rvalid_l), 16'd1);
    chk(req, rdata_l, exp);
    idle(0);
  endtask

  task automatic t_reset();
    chk("R1 valid_l", DW'(rvalid_l), 16'd0);
    chk("R1 valid_r", DW'(rvalid_r), 16'd0);
    chk("R1 data_l", rdata_l, 16'h0000);
    // counter at 0: hold-mode write lands on address 0
    drive(0, 1, 1, 1, 10'd77, 0, 1, 0, 0, 0, 16'h0F0F); step(); idle(0);
    read_left("R1 counter zero", 10'd0, 16'h0F0F);
  endtask

  task automatic t_bytes();
    wr(0, 10'd5, 16'hA5A5); step();
    drive(0, 1, 0, 1, 10'd5, 0, 1, 0, 0, 1, 16'h1234); step();
    drive(0, 1, 0, 1, 10'd5, 0, 1, 0, 1, 0, 16'h00CC); step();
    rd(0, 10'd5); step();
    chk("R4 flow valid", DW'(rvalid_l), 16'd1);
    chk("R3 lane merge", rdata_l, 16'h12CC);
    idle(0); step();
    chk("R4 one cycle", DW'(rvalid_l), 16'd0);
  endtask

  task automatic t_select();
    drive(0, 1, 0, 1, 10'd5, 1, 1, 0, 0, 0, 16'hFFFF); step();
    drive(0, 1, 0, 1, 10'd5, 0, 0, 0, 0, 0, 16'hEEEE); step();
    drive(0, 1, 0, 1, 10'd5, 1, 1, 1, 1, 1, 16'h0000); step();
    chk("R2 deselected read", DW'(rvalid_l), 16'd0);
    idle(0);
    read_left("R2 no write", 10'd5, 16'h12CC);
  endtask

  task automatic t_pipe();
    pipe[1] = 1'b1;
    rd(1, 10'd5); step();
    chk("R5 not yet", DW'(rvalid_r), 16'd0);
    idle(1); step();
    chk("R5 valid", DW'(rvalid_r), 16'd1);
    chk("R5 data", rdata_r, 16'h12CC);
    step();
    chk("R5 ends", DW'(rvalid_r), 16'd0);
    pipe[1] = 1'b0;
  endtask

  task automatic t_burst();
    wr(0, 10'd100, 16'h1000); step();
    drive(0, 1, 1, 0, 10'd0, 0, 1, 0, 0, 0, 16'h1001); step();
    drive(0, 1, 1, 0, 10'd0, 0, 1, 0, 0, 0, 16'h1002); step();
    rd(0, 10'd100); step();
    chk("R6 load", rdata_l, 16'h1000);
    drive(0, 1, 1, 0, 10'd0, 0, 1, 1, 1, 1, '0); step();
    chk("R6 step", rdata_l, 16'h1001);
    drive(0, 1, 1, 1, 10'd0, 0, 1, 1, 1, 1, '0); step();
    chk("R6 hold", rdata_l, 16'h1001);
    drive(0, 1, 0, 0, 10'd102, 0, 1, 1, 1, 1, '0); step();
    chk("R6 load over step", rdata_l, 16'h1002);
    idle(0);
  endtask

  task automatic t_clear();
    wr(0, 10'd50, 16'h5050); step();
    drive(0, 0, 0, 0, 10'd50, 0, 1, 0, 0, 0, 16'h0BAD); step();
    idle(0);
    read_left("R7 write at 0", 10'd0, 16'h0BAD);
    read_left("R7 addr kept", 10'd50, 16'h5050);
    drive(0, 0, 1, 1, 10'd50, 0, 1, 1, 1, 1, '0); step();
    chk("R7 read at 0", rdata_l, 16'h0BAD);
    idle(0);
  endtask

  task automatic t_wrap();
    wr(0, 10'd1023, 16'h3FF0); step();
    drive(0, 1, 1, 0, 10'd0, 0, 1, 0, 0, 0, 16'hABCD); step();
    idle(0);
    read_left("R8 top", 10'd1023, 16'h3FF0);
    read_left("R8 wrapped write", 10'd0, 16'hABCD);
    rd(0, 10'd1023); step();
    drive(0, 1, 1, 0, 10'd0, 0, 1, 1, 1, 1, '0); step();
    chk("R8 wrapped read", rdata_l, 16'hABCD);
    idle(0);
  endtask

  task automatic t_oe();
    rd(0, 10'd100); step();
    idle(0);
    chk("R9 before", rdata_l, 16'h1000);
    oe_n[0] = 1'b1; #1;
    chk("R9 valid off", DW'(rvalid_l), 16'd0);
    chk("R9 data off", rdata_l, 16'h0000);
    oe_n[0] = 1'b0; #1;
    chk("R9 restored", rdata_l, 16'h1000);
    step();
  endtask

  task automatic t_cross();
    wr(0, 10'd200, 16'h2222); step();
    wr(0, 10'd200, 16'h7777); rd(1, 10'd200); step();
    chk("R10 old value", rdata_r, 16'h2222);
    idle(0); rd(1, 10'd200); step();
    chk("R10 new value", rdata_r, 16'h7777);
    rd(0, 10'd200); rd(1, 10'd200); step();
    chk("R10 both left", rdata_l, 16'h7777);
    chk("R10 both right", rdata_r, 16'h7777);
    idle(0); idle(1);
  endtask

  task automatic t_collide();
    wr(0, 10'd300, 16'hAAAA); wr(1, 10'd300, 16'h5555); step();
    idle(1);
    read_left("R11 left wins", 10'd300, 16'hAAAA);
    drive(0, 1, 0, 1, 10'd301, 0, 1, 0, 1, 0, 16'h00BB); wr(1, 10'd301, 16'hCCDD); step();
    idle(0); rd(1, 10'd301); step();
    chk("R11 lane split", rdata_r, 16'hCCBB);
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int p = 0; p < 2; p++) begin
      idle(p);
      oe_n[p] = 1'b0;
      pipe[p] = 1'b0;
    end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_bytes();
    t_select();
    t_pipe();
    t_burst();
    t_clear();
    t_wrap();
    t_oe();
    t_cross();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule